// File: doc/BRIEF.md
# Guest Bus Mailbox Controller

This block lets a host run single byte transfers to peripherals on a narrow local bus. The bus has eight peripheral slots, called guests, and each guest has eight byte registers. The host writes one command word. That word carries the transfer direction, the guest number, the register number, the write byte and a flag that enables timeout checking. The block then drives the guest's select line and a read or write strobe for the number of cycles set for that guest. It stretches the strobe for as long as the guest holds its wait line high.

The same command word reports progress. A busy flag stays set until the transfer ends. After a read, the guest's byte appears in the low byte of the word. If the wait line stays high up to a fixed limit, the strobe is cut off and the transfer still completes. A guest whose wait line is not connected therefore never hangs the block. In that case the timeout flag records the event, but only when timeout checking was enabled for that command.

A second host register holds one 4-bit strobe length field per guest.

Top module: `gbus_mailbox`

## Requirements
- R1: After reset the command register reads 0, the timing register reads 0x22228888 (guests 0 to 3 at 8 cycles, guests 4 to 7 at 2 cycles) and no guest select or strobe is active.
- R2: The command register (host_addr 0) uses these bits: [31] busy (read only), [30] timeout arm on write and timeout flag on read, [24] direction (1 write, 0 read), [22:20] guest, [18:16] register, [7:0] data. Busy reads 1 from the cycle after an accepted write until the transfer completes.
- R3: During a transfer exactly one select bit is high, bit gb_sel[guest]. It stays unchanged for the whole strobe. gb_addr carries the register number.
- R4: With the wait line low, the strobe lasts exactly the guest's field in the timing register (host_addr 1, guest g at bits [4g+3:4g]) in clock cycles. A field value of 0 means 16 cycles.
- R5: A write drives gb_wr and puts the data byte on gb_dout. A read drives gb_rd. When busy clears, the read byte from gb_din, sampled in the last strobe cycle, appears in bits [7:0].
- R6: A strobe ends in the first cycle that is at least the programmed length and in which gb_wait is sampled low.
- R7: If gb_wait stays high, the strobe ends after TMO_LIMIT cycles and busy clears. Bit 30 then reads 1 only if the command was written with bit 30 set.
- R8: A command write accepted while busy is set is ignored. The running transfer and the fields read back do not change.
- R9: A host write to the timing register updates the per-guest lengths used by later commands and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 1 | 0 selects the command register, 1 selects the timing register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register |
| gb_sel | output | 8 | One-hot guest select |
| gb_rd | output | 1 | Read strobe |
| gb_wr | output | 1 | Write strobe |
| gb_addr | output | 3 | Guest register number |
| gb_dout | output | 8 | Write byte to the guest |
| gb_din | input | 8 | Read byte from the guest |
| gb_wait | input | 1 | Guest wait line; high stretches the strobe |

## Verification
The bench builds the block with TMO_LIMIT set to 40 instead of 256. This makes the cut-off path short enough that many commands per run can reach it. It also lets the programmed length, a stretched strobe that ends below the limit and a strobe that runs into the limit all appear in the same random mix. Because every length field is at most 16, a wait of 39 cycles or less always ends normally and a stuck wait always hits the limit. That puts the boundary between R6 and R7 within reach of the random stimulus.

// File: rtl/gbm_pkg.sv
package gbm_pkg;
  localparam int GID_W   = 3;
  localparam int RID_W   = 3;
  localparam int FIELD_W = 4;
  localparam int SLEN_W  = FIELD_W + 1;

  // command word bit positions (software-visible layout)
  localparam int POS_BUSY = 31;
  localparam int POS_TMO  = 30;
  localparam int POS_DIR  = 24;
  localparam int GID_LSB  = 20;
  localparam int RID_LSB  = 16;

  typedef enum logic {GB_READ = 1'b0, GB_WRITE = 1'b1} gb_dir_e;

  // programmed field to strobe length; zero selects the longest setting
  function automatic logic [SLEN_W-1:0] strobe_cycles(input logic [FIELD_W-1:0] f);
    return (f == '0) ? SLEN_W'(1 << FIELD_W) : {1'b0, f};
  endfunction
endpackage

// File: rtl/gbm_timing_cfg.sv
module gbm_timing_cfg
  import gbm_pkg::*;
#(
  parameter int NUM_GUESTS = 8,
  parameter logic [NUM_GUESTS*FIELD_W-1:0] RESET_VAL = 32'h2222_8888
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [NUM_GUESTS*FIELD_W-1:0] wdata,
  input  logic [GID_W-1:0]              gid_sel,
  output logic [NUM_GUESTS*FIELD_W-1:0] cfg_q,
  output logic [SLEN_W-1:0]             len_o
);
  logic [FIELD_W-1:0] field_q [NUM_GUESTS];

  for (genvar g = 0; g < NUM_GUESTS; g++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     field_q[g] <= RESET_VAL[g*FIELD_W +: FIELD_W];
      else if (wr_en) field_q[g] <= wdata[g*FIELD_W +: FIELD_W];
    end
    assign cfg_q[g*FIELD_W +: FIELD_W] = field_q[g];
  end

  assign len_o = strobe_cycles(field_q[gid_sel]);
endmodule

// File: rtl/gbm_sequencer.sv
module gbm_sequencer
  import gbm_pkg::*;
#(
  parameter int LIMIT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLEN_W-1:0] len_i,
  input  logic              wait_i,
  output logic              active_o,
  output logic              done_o,
  output logic              limit_hit_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [SLEN_W-1:0] len_q;
  logic              normal_end, limit_reach;

  assign cnt_nxt     = cnt + CNT_W'(1);
  assign normal_end  = (cnt_nxt >= CNT_W'(len_q)) && !wait_i;
  assign limit_reach = (cnt_nxt == CNT_W'(LIMIT));
  assign done_o      = active_q && (normal_end || limit_reach);
  assign limit_hit_o = done_o && !normal_end;
  assign active_o    = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt      <= '0;
      len_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt      <= '0;
      len_q    <= len_i;
    end else if (done_o) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt <= cnt_nxt;
    end
  end

  // R4: a strobe never ends before its programmed length
  a_r4_min_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> (CNT_W'($past(cnt) + CNT_W'(1)) >= CNT_W'($past(len_q))));
  // R6: a held wait line keeps the strobe running below the limit
  a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && wait_i && !limit_reach |=> active_o);
  // R7: the strobe counter never reaches the limit while active
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt < CNT_W'(LIMIT)));
endmodule

// File: rtl/gbus_mailbox.sv
module gbus_mailbox
  import gbm_pkg::*;
#(
  parameter int TMO_LIMIT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic [7:0]  gb_sel,
  output logic        gb_rd,
  output logic        gb_wr,
  output logic [2:0]  gb_addr,
  output logic [7:0]  gb_dout,
  input  logic [7:0]  gb_din,
  input  logic        gb_wait
);
  localparam int NUM_GUESTS = 1 << GID_W;

  gb_dir_e            dir_q;
  logic [GID_W-1:0]   gid_q;
  logic [RID_W-1:0]   rid_q;
  logic [7:0]         data_q;
  logic               arm_q, tmo_q;
  logic               busy, seq_done, limit_hit, accept, cfg_wr;
  logic [SLEN_W-1:0]  start_len;
  logic [NUM_GUESTS*FIELD_W-1:0] cfg_q;
  logic               unused_cmd_bits;

  assign accept = host_wr && !host_addr && !busy;
  assign cfg_wr = host_wr && host_addr;
  assign unused_cmd_bits = ^{host_wdata[POS_BUSY], host_wdata[29:25], host_wdata[23],
                             host_wdata[19], host_wdata[15:8]};

  gbm_timing_cfg #(.NUM_GUESTS(NUM_GUESTS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(host_wdata),
    .gid_sel(host_wdata[GID_LSB +: GID_W]), .cfg_q(cfg_q), .len_o(start_len));

  gbm_sequencer #(.LIMIT(TMO_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .len_i(start_len), .wait_i(gb_wait),
    .active_o(busy), .done_o(seq_done), .limit_hit_o(limit_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= GB_READ;
      gid_q  <= '0;
      rid_q  <= '0;
      data_q <= '0;
      arm_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else if (accept) begin
      dir_q  <= gb_dir_e'(host_wdata[POS_DIR]);
      gid_q  <= host_wdata[GID_LSB +: GID_W];
      rid_q  <= host_wdata[RID_LSB +: RID_W];
      data_q <= host_wdata[7:0];
      arm_q  <= host_wdata[POS_TMO];
      tmo_q  <= 1'b0;
    end else if (seq_done) begin
      if (dir_q == GB_READ) data_q <= gb_din;
      tmo_q <= limit_hit && arm_q;
    end
  end

  for (genvar g = 0; g < NUM_GUESTS; g++) begin : g_sel
    assign gb_sel[g] = busy && (gid_q == GID_W'(g));
  end

  assign gb_rd   = busy && (dir_q == GB_READ);
  assign gb_wr   = busy && (dir_q == GB_WRITE);
  assign gb_addr = rid_q;
  assign gb_dout = data_q;

  always_comb begin
    host_rdata = '0;
    if (host_addr) begin
      host_rdata = cfg_q;
    end else begin
      host_rdata[POS_BUSY]              = busy;
      host_rdata[POS_TMO]               = tmo_q;
      host_rdata[POS_DIR]               = dir_q;
      host_rdata[GID_LSB +: GID_W]      = gid_q;
      host_rdata[RID_LSB +: RID_W]      = rid_q;
      host_rdata[7:0]                   = data_q;
    end
  end

  // R3: at most one guest selected
  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gb_sel));
  // R3: selection does not move while a strobe continues
  a_r3_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !seq_done |=> $stable(gb_sel) && ($countones(gb_sel) == 1));
  // R8: a command written while busy leaves the held command intact
  a_r8_ignored_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !seq_done && host_wr && !host_addr |=>
      $stable(gid_q) && $stable(rid_q) && $stable(dir_q) && $stable(data_q));
  // R7: the timeout flag only rises after a limit cut-off
  a_r7_tmo_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(limit_hit));
  // R5: strobes are mutually exclusive
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(gb_rd && gb_wr));
endmodule

// File: tb/test_gbus_mailbox.sv
module test_gbus_mailbox;
  localparam int LIM = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_addr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [7:0]  gb_sel;
  logic        gb_rd, gb_wr;
  logic [2:0]  gb_addr;
  logic [7:0]  gb_dout;
  logic [7:0]  gb_din = '0;
  logic        gb_wait = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] cfg_model = 32'h2222_8888;

  gbus_mailbox #(.TMO_LIMIT(LIM)) i_gbus_mailbox (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .gb_sel(gb_sel),
    .gb_rd(gb_rd), .gb_wr(gb_wr), .gb_addr(gb_addr), .gb_dout(gb_dout),
    .gb_din(gb_din), .gb_wait(gb_wait));

  always #2 clk = ~clk;

  function automatic logic [7:0] guest_byte(input logic [2:0] g, input logic [2:0] r);
    return {g, r, 2'b01} ^ 8'h5A;
  endfunction

  function automatic int eff_len(input logic [3:0] f);
    return (f == 4'd0) ? 16 : int'(f);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    host_addr = 1'b1; host_wdata = v; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    cfg_model = v;
    check("R9 cfg readback", host_rdata, v);
    host_addr = 1'b0;
  endtask

  task automatic run_cmd(input bit dir, input logic [2:0] gid, input logic [2:0] rid,
                         input logic [7:0] data, input bit arm, input int w, input int inject);
    int k = 0;
    bit sel_ok = 1'b1;
    int span, exp_k;
    bit exp_tmo;
    string tag;
    @(negedge clk);
    host_addr  = 1'b0;
    host_wdata = {1'b0, arm, 5'b0, dir, 1'b0, gid, 1'b0, rid, 8'h00, data};
    host_wr    = 1'b1;
    gb_din     = guest_byte(gid, rid);
    gb_wait    = (w > 0);
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0;
    check("R2 busy set", 32'(host_rdata[31]), 32'd1);
    while (gb_sel != 8'h00 && k < 1000) begin
      k++;
      if (gb_sel != (8'b1 << gid) || gb_addr != rid || gb_wr != dir || gb_rd != !dir ||
          (dir && gb_dout != data)) sel_ok = 1'b0;
      gb_wait = (k <= w);
      if (k == inject) begin
        host_wdata = {1'b0, 1'b1, 5'b0, !dir, 1'b0, gid ^ 3'd5, 1'b0, rid ^ 3'd3, 8'h00, ~data};
        host_wr = 1'b1;
      end else begin
        host_wr = 1'b0;
      end
      @(negedge clk);
    end
    host_wr = 1'b0;
    gb_wait = 1'b0;
    span    = (eff_len(cfg_model[gid*4 +: 4]) > w + 1) ? eff_len(cfg_model[gid*4 +: 4]) : w + 1;
    exp_k   = (span > LIM) ? LIM : span;
    exp_tmo = (span > LIM) && arm;
    tag     = (w == 0) ? "R4 strobe length" : ((span > LIM) ? "R7 cut-off length" : "R6 stretched length");
    check("R3 select/addr/strobe", 32'(sel_ok), 32'd1);
    check(tag, k, exp_k);
    check("R2 busy cleared", 32'(host_rdata[31]), 32'd0);
    check("R7 timeout flag", 32'(host_rdata[30]), 32'(exp_tmo));
    check("R5 data byte", 32'(host_rdata[7:0]), dir ? 32'(data) : 32'(guest_byte(gid, rid)));
    if (inject > 0)
      check("R8 held command", 32'(host_rdata[24:16]), 32'({dir, 1'b0, gid, 1'b0, rid}));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    host_addr = 1'b0;
    #0 check("R1 cmd reset", host_rdata, 32'h0);
    check("R1 select idle", 32'({gb_sel, gb_rd, gb_wr}), 32'h0);
    host_addr = 1'b1;
    #1 check("R1 cfg reset", host_rdata, 32'h2222_8888);
    host_addr = 1'b0;

    run_cmd(1'b1, 3'd2, 3'd6, 8'hC3, 1'b0, 0, 0);    // R4 default length 8, write
    run_cmd(1'b0, 3'd5, 3'd1, 8'h00, 1'b1, 5, 0);    // R6 length 2 stretched to 6
    run_cmd(1'b0, 3'd7, 3'd7, 8'h00, 1'b0, 0, 0);    // R4 top guest/reg, length 2
    write_cfg(32'h1234_5F01);                        // R9
    run_cmd(1'b1, 3'd1, 3'd0, 8'h11, 1'b0, 0, 0);    // R4 field 0 -> 16
    run_cmd(1'b0, 3'd0, 3'd4, 8'h00, 1'b0, 0, 0);    // R4 field 1
    run_cmd(1'b0, 3'd3, 3'd2, 8'h00, 1'b1, 1000, 0); // R7 stuck wait, armed
    run_cmd(1'b1, 3'd4, 3'd5, 8'h77, 1'b0, 1000, 0); // R7 stuck wait, not armed
    run_cmd(1'b1, 3'd2, 3'd3, 8'hA5, 1'b1, LIM - 1, 0); // R6 ends exactly at limit
    run_cmd(1'b0, 3'd6, 3'd1, 8'h00, 1'b1, 10, 3);   // R8 command while busy

    for (int i = 0; i < 40; i++) begin
      int r = $urandom;
      int w = (r % 4 == 0) ? 1000 : ((r >> 4) % 20);
      if (i % 10 == 9) write_cfg($urandom);
      run_cmd(r[8], 3'(r >> 9), 3'(r >> 12), 8'(r >> 16), r[24], w,
              (r % 7 == 0) ? 1 : 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule